// File: doc/BRIEF.md
# Two-Level Hadamard Macroblock Cost Unit

This block scores a 16×16 block of prediction residuals by the sum of absolute transformed differences. It splits the block into sixteen 4×4 sub-blocks and applies a 4×4 Hadamard transform to each one. The sixteen DC terms are then arranged as a 4×4 matrix, and that matrix is transformed a second time. The cost adds the magnitudes of every non-DC first-level coefficient to the magnitudes of all sixteen second-level coefficients. A mode-decision stage sends one residual set for each candidate predictor and compares the costs that come back.

Residuals arrive one per valid cycle. A start flag marks the first sample of each set. The final cost appears on a registered output together with a one-cycle done strobe, and it stays there until the next result replaces it. A new set may begin in the cycle right after the previous set's last sample, so costs for successive modes can be streamed with no idle cycles. Only additions and subtractions are used, and the datapath is wide enough that no intermediate value or the total ever wraps.

Top module: `mb_satd_cost`

## Requirements
- R1: While reset is asserted and after it is released, `cost_out` is 0 and `cost_done` is 0 until the first cost is produced.
- R2: A sample is taken on every cycle in which `in_valid` is high and a set is open. A set holds 256 samples. Sub-block k (0..15) covers rows 4·(k/4)..4·(k/4)+3 and columns 4·(k%4)..4·(k%4)+3. Sub-blocks are sent in increasing k, and the samples inside each one are sent in raster order. Cycles with `in_valid` low may appear anywhere and have no effect.
- R3: Each sub-block X is transformed as Y = H·X·Hᵀ with the ±1 Hadamard matrix, without scaling. The magnitudes of its 15 non-DC coefficients are added to the cost. The DC term itself is not added.
- R4: Each DC term (the plain sum of its sub-block) is placed at row k/4, column k%4 of a 4×4 matrix. That matrix gets the same transform, and the magnitudes of all 16 of its coefficients are added to the cost.
- R5: `cost_out` is a 20-bit unsigned value equal to the exact total of R3 and R4. It never wraps, because the total of any valid input is at most 524288.
- R6: `cost_done` is high for exactly one cycle, five rising edges after the edge that captured the set's 256th sample. `cost_out` takes the new value in that same cycle and holds it until the next strobe. A set that never completes produces no strobe.
- R7: A set may start in the cycle right after the previous set's last sample. Each set then gets its own correct cost and its own strobe, in arrival order.
- R8: `in_start` together with `in_valid` always begins a new set with that sample as sample 0. Any unfinished set is dropped and contributes nothing to any reported cost.
- R9: Samples with `in_valid` high and `in_start` low are ignored when no set is open, which is the case after reset and after a set's 256th sample. `in_start` is ignored in any cycle where `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Residual sample present this cycle |
| in_start | input | 1 | With `in_valid`, marks sample 0 of a new set |
| in_res | input | 9 | Signed two's-complement residual |
| cost_out | output | 20 | Unsigned cost of the last completed set |
| cost_done | output | 1 | One-cycle strobe when `cost_out` updates |

## Verification
The bench drives flat sets at both extremes of the input range. At the negative extreme the second-level DC reaches 65536, so a second-level path narrower than 17 bits would report a wrong cost. A checkerboard set puts all the energy into first-level AC terms, which catches a design that drops or double-counts the excluded DC. A set whose sub-blocks each have a different constant catches any mix-up in how the DC matrix is arranged. Further tests send sets back to back, with gaps, with a start pulse that has no valid, with stray samples outside any set, and with a set aborted partway through. These catch an accumulator that leaks between sets, a counter that does not restart, and a strobe that arrives on the wrong edge or fires for an incomplete set.

// File: rtl/satd_pkg.sv
// Shared constants and types for the two-level Hadamard cost unit.
// Assumes a 16x16 macroblock split into sixteen 4x4 sub-blocks.
package satd_pkg;
    localparam int SUB_DIM = 4;
    localparam int SUB_PIX = SUB_DIM * SUB_DIM;
    localparam int SUB_CNT = 16;
    localparam int MB_PIX  = SUB_PIX * SUB_CNT;
    localparam int IDX_W   = $clog2(SUB_CNT);
    localparam int PIX_W   = $clog2(SUB_PIX);
    localparam int POS_W   = $clog2(MB_PIX);

    // Tag that travels with a completed sub-block through the pipeline.
    typedef struct packed {
        logic             first;
        logic             last;
        logic [IDX_W-1:0] idx;
    } sub_tag_t;
endpackage

// File: rtl/satd_gather.sv
// Collects the residual stream into whole 4x4 sub-blocks.
// Tracks the position inside the open macroblock, opens a new block on
// start+valid and closes it after the final sample. Each finished
// sub-block is presented for one cycle on blk_pix with its tag.
// Assumes samples arrive in sub-block order, raster order inside each.
module satd_gather
    import satd_pkg::*;
#(
    parameter int IN_W = 9
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_start,
    input  logic signed [IN_W-1:0] in_res,
    output logic signed [IN_W-1:0] blk_pix [SUB_PIX],
    output logic                   blk_vld,
    output sub_tag_t               blk_tag
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(MB_PIX - 1);
    localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(SUB_PIX - 1);
    localparam logic [IDX_W-1:0] LAST_SUB = IDX_W'(SUB_CNT - 1);

    logic                   open_q;
    logic [POS_W-1:0]       cnt_q;
    logic signed [IN_W-1:0] hold_q [SUB_PIX];
    logic                   take;
    logic [POS_W-1:0]       pos;
    logic [PIX_W-1:0]       pix_i;
    logic [IDX_W-1:0]       sub_i;

    // Decide whether this cycle's sample belongs to a block and where.
    always_comb begin
        take  = in_valid && (in_start || open_q);
        pos   = in_start ? '0 : cnt_q;
        pix_i = pos[PIX_W-1:0];
        sub_i = pos[POS_W-1:PIX_W];
    end

    // Position counter and open flag of the current macroblock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (take) begin
            cnt_q  <= POS_W'(pos + 1'b1);
            open_q <= (pos != LAST_POS);
        end
    end

    // Sample holding buffer for the sub-block being filled.
    always_ff @(posedge clk) begin
        if (take) begin
            hold_q[pix_i] <= in_res;
        end
    end

    // Hand a finished sub-block to the transform stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_vld <= 1'b0;
            blk_tag <= '0;
        end else begin
            blk_vld <= take && (pix_i == LAST_PIX);
            if (take && (pix_i == LAST_PIX)) begin
                blk_tag.first <= (sub_i == '0);
                blk_tag.last  <= (sub_i == LAST_SUB);
                blk_tag.idx   <= sub_i;
            end
        end
    end

    // Snapshot of the full sub-block, the last sample taken from the port.
    always_ff @(posedge clk) begin
        if (take && (pix_i == LAST_PIX)) begin
            for (int k = 0; k < SUB_PIX - 1; k++) begin
                blk_pix[k] <= hold_q[k];
            end
            blk_pix[SUB_PIX-1] <= in_res;
        end
    end

    // R2: a sub-block needs 16 samples, so two back-to-back hand-overs are impossible.
    assert_blk_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        blk_vld |=> !blk_vld);
endmodule

// File: rtl/satd_hadamard4.sv
// Combinational unscaled 4x4 Hadamard transform, Y = H * X * H^T.
// Row butterflies first, then column butterflies, adds and subtracts only.
// Output width grows by two bits per dimension so no result can wrap.
// Element order is raster: index = row*4 + column. Output 0 is the DC term.
module satd_hadamard4
    import satd_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int OUT_W = IN_W + 4
) (
    input  logic signed [IN_W-1:0]  x [SUB_PIX],
    output logic signed [OUT_W-1:0] y [SUB_PIX]
);
    localparam int MID_W = IN_W + 2;

    logic signed [MID_W-1:0] rw [SUB_PIX];

    // Horizontal pass: one butterfly network per row.
    for (genvar r = 0; r < SUB_DIM; r++) begin : g_row
        logic signed [MID_W-1:0] e0, e1, e2, e3, s01, d01, s23, d23;
        assign e0  = MID_W'(x[r*SUB_DIM + 0]);
        assign e1  = MID_W'(x[r*SUB_DIM + 1]);
        assign e2  = MID_W'(x[r*SUB_DIM + 2]);
        assign e3  = MID_W'(x[r*SUB_DIM + 3]);
        assign s01 = e0 + e1;
        assign d01 = e0 - e1;
        assign s23 = e2 + e3;
        assign d23 = e2 - e3;
        assign rw[r*SUB_DIM + 0] = s01 + s23;
        assign rw[r*SUB_DIM + 1] = s01 - s23;
        assign rw[r*SUB_DIM + 2] = d01 - d23;
        assign rw[r*SUB_DIM + 3] = d01 + d23;
    end

    // Vertical pass: one butterfly network per column of the row results.
    for (genvar c = 0; c < SUB_DIM; c++) begin : g_col
        logic signed [OUT_W-1:0] f0, f1, f2, f3, s01, d01, s23, d23;
        assign f0  = OUT_W'(rw[0*SUB_DIM + c]);
        assign f1  = OUT_W'(rw[1*SUB_DIM + c]);
        assign f2  = OUT_W'(rw[2*SUB_DIM + c]);
        assign f3  = OUT_W'(rw[3*SUB_DIM + c]);
        assign s01 = f0 + f1;
        assign d01 = f0 - f1;
        assign s23 = f2 + f3;
        assign d23 = f2 - f3;
        assign y[0*SUB_DIM + c] = s01 + s23;
        assign y[1*SUB_DIM + c] = s01 - s23;
        assign y[2*SUB_DIM + c] = d01 - d23;
        assign y[3*SUB_DIM + c] = d01 + d23;
    end
endmodule

// File: rtl/satd_abs_sum.sv
// Combinational sum of magnitudes of a set of signed coefficients.
// SKIP_DC selects the variant that leaves element 0 out of the sum.
// Assumes SUM_W is wide enough for N times the largest magnitude.
module satd_abs_sum #(
    parameter int N       = 16,
    parameter int W       = 13,
    parameter int SUM_W   = 20,
    parameter bit SKIP_DC = 1'b0
) (
    input  logic signed [W-1:0] c [N],
    output logic [SUM_W-1:0]    total
);
    localparam int START = SKIP_DC ? 1 : 0;

    // Add the unsigned magnitude of every selected coefficient.
    always_comb begin
        logic [W-1:0] mag;
        total = '0;
        mag   = '0;
        for (int i = START; i < N; i++) begin
            mag   = c[i][W-1] ? W'(-c[i]) : W'(c[i]);
            total = total + SUM_W'(mag);
        end
    end
endmodule

// File: rtl/mb_satd_cost.sv
// Two-level Hadamard cost of a 16x16 residual macroblock.
// Stage 1 transforms each finished 4x4 sub-block and registers the sum of
// its AC magnitudes and its DC term. Stage 2 adds the AC sum into the
// accumulator (loading it on a block's first sub-block) and files the DC
// into a 4x4 matrix. After the last sub-block the matrix is transformed,
// its full magnitude sum is added, and one cycle later the result is
// published with a one-cycle done strobe.
// Assumes each set is 256 samples, so sub-block results are at least
// 16 cycles apart and never collide with the second-level add.
module mb_satd_cost
    import satd_pkg::*;
#(
    parameter int IN_W  = 9,
    parameter int ACC_W = 20
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   in_start,
    input  logic signed [IN_W-1:0] in_res,
    output logic [ACC_W-1:0]       cost_out,
    output logic                   cost_done
);
    localparam int L1_W = IN_W + 4;
    localparam int L2_W = L1_W + 4;

    logic signed [IN_W-1:0] blk_pix [SUB_PIX];
    logic                   blk_vld;
    sub_tag_t               blk_tag;
    logic signed [L1_W-1:0] c1 [SUB_PIX];
    logic [ACC_W-1:0]       ac_abs;
    logic                   s1_vld;
    sub_tag_t               s1_tag;
    logic [ACC_W-1:0]       s1_ac;
    logic signed [L1_W-1:0] s1_dc;
    logic signed [L1_W-1:0] dc_mat [SUB_CNT];
    logic                   l2_go;
    logic signed [L2_W-1:0] c2 [SUB_PIX];
    logic [ACC_W-1:0]       l2_abs;
    logic                   l2_vld;
    logic [ACC_W-1:0]       l2_sum;
    logic [ACC_W-1:0]       acc_q;
    logic                   fin_q;
    logic [ACC_W-1:0]       add_term;
    logic [ACC_W:0]         acc_wide;

    satd_gather #(.IN_W(IN_W)) u_gather (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_start (in_start),
        .in_res   (in_res),
        .blk_pix  (blk_pix),
        .blk_vld  (blk_vld),
        .blk_tag  (blk_tag)
    );

    satd_hadamard4 #(.IN_W(IN_W), .OUT_W(L1_W)) u_had_l1 (
        .x (blk_pix),
        .y (c1)
    );

    satd_abs_sum #(.N(SUB_PIX), .W(L1_W), .SUM_W(ACC_W), .SKIP_DC(1'b1)) u_sum_l1 (
        .c     (c1),
        .total (ac_abs)
    );

    satd_hadamard4 #(.IN_W(L1_W), .OUT_W(L2_W)) u_had_l2 (
        .x (dc_mat),
        .y (c2)
    );

    satd_abs_sum #(.N(SUB_PIX), .W(L2_W), .SUM_W(ACC_W), .SKIP_DC(1'b0)) u_sum_l2 (
        .c     (c2),
        .total (l2_abs)
    );

    // Stage 1 register: first-level AC sum, DC term and tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_tag <= '0;
            s1_ac  <= '0;
            s1_dc  <= '0;
        end else begin
            s1_vld <= blk_vld;
            if (blk_vld) begin
                s1_tag <= blk_tag;
                s1_ac  <= ac_abs;
                s1_dc  <= c1[0];
            end
        end
    end

    // DC matrix filled by sub-block index; trigger level 2 after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_go <= 1'b0;
            for (int k = 0; k < SUB_CNT; k++) begin
                dc_mat[k] <= '0;
            end
        end else begin
            l2_go <= s1_vld && s1_tag.last;
            if (s1_vld) begin
                dc_mat[s1_tag.idx] <= s1_dc;
            end
        end
    end

    // Level-2 register: magnitude sum of the transformed DC matrix.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l2_vld <= 1'b0;
            l2_sum <= '0;
        end else begin
            l2_vld <= l2_go;
            if (l2_go) begin
                l2_sum <= l2_abs;
            end
        end
    end

    // Pick the term entering the accumulator and form the wide sum.
    always_comb begin
        add_term = s1_vld ? s1_ac : l2_sum;
        acc_wide = {1'b0, acc_q} + {1'b0, add_term};
    end

    // Accumulator: loads on the first sub-block of a set, adds otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (s1_vld && s1_tag.first) begin
            acc_q <= s1_ac;
        end else if (s1_vld || l2_vld) begin
            acc_q <= acc_wide[ACC_W-1:0];
        end
    end

    // Publish the finished cost one cycle after its last contribution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q     <= 1'b0;
            cost_done <= 1'b0;
            cost_out  <= '0;
        end else begin
            fin_q     <= l2_vld;
            cost_done <= fin_q;
            if (fin_q) begin
                cost_out <= acc_q;
            end
        end
    end

    // R5: adding a contribution never carries out of the accumulator.
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_tag.first) || (l2_vld && !s1_vld) |-> !acc_wide[ACC_W]);

    // R7: a sub-block result and the level-2 sum never compete for the adder.
    assert_no_collide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(s1_vld && l2_vld));

    // R6: the done strobe lasts one cycle only.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cost_done |=> !cost_done);

    // R6: the strobe follows a level-2 add made two edges earlier.
    assert_done_after_l2_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cost_done) |-> $past(l2_vld, 2));
endmodule

// File: tb/sim_mb_satd_cost.sv
// Bench for mb_satd_cost: a behavioural cost model fed by the same stimulus,
// compared against the outputs on every clock.
module sim_mb_satd_cost;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W = 9;
    localparam int ACC_W = 20;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_start = 1'b0;
    logic signed [IN_W-1:0] in_res = '0;
    logic [ACC_W-1:0]       cost_out;
    logic                   cost_done;

    int    n_chk = 0;
    int    n_fail = 0;
    int    ecnt = 0;
    bit    run_chk = 1'b0;
    bit    ended = 1'b0;
    int    arr [16][16];
    int    q_edge [$];
    int    q_val [$];
    string q_tag [$];
    int    hold_val = 0;
    string hold_tag = "R1";

    mb_satd_cost #(.IN_W(IN_W), .ACC_W(ACC_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_start  (in_start),
        .in_res    (in_res),
        .cost_out  (cost_out),
        .cost_done (cost_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) ecnt <= ecnt + 1;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d (edge %0d)", tag, act, exp, ecnt);
        end
    endtask

    task automatic finish_up();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Walsh-ordered Hadamard sign; row order does not change magnitude sums.
    function automatic int hs(input int u, input int i);
        return ($countones(u & i) % 2 == 1) ? -1 : 1;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference cost straight from the requirements (R3, R4, R5).
    function automatic int model_cost();
        int dc [4][4];
        int tot = 0;
        for (int k = 0; k < 16; k++) begin
            for (int u = 0; u < 4; u++) begin
                for (int v = 0; v < 4; v++) begin
                    int y = 0;
                    for (int i = 0; i < 4; i++)
                        for (int j = 0; j < 4; j++)
                            y += hs(u, i) * hs(v, j) * arr[4*(k/4)+i][4*(k%4)+j];
                    if (u == 0 && v == 0) dc[k/4][k%4] = y;
                    else tot += iabs(y);
                end
            end
        end
        for (int u = 0; u < 4; u++)
            for (int v = 0; v < 4; v++) begin
                int y = 0;
                for (int i = 0; i < 4; i++)
                    for (int j = 0; j < 4; j++)
                        y += hs(u, i) * hs(v, j) * dc[i][j];
                tot += iabs(y);
            end
        return tot;
    endfunction

    // Fill the 16x16 residual array with one of several patterns.
    task automatic fill(input int pat);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin
                case (pat)
                    0: arr[r][c] = 0;
                    1: arr[r][c] = 255;
                    2: arr[r][c] = -256;
                    3: arr[r][c] = ((r + c) % 2 == 1) ? -256 : 255;
                    4: arr[r][c] = int'($urandom_range(511)) - 256;
                    default: arr[r][c] = (((r/4)*4 + (c/4)) * 73 % 512) - 256;
                endcase
            end
    endtask

    // Drive one full set in sub-block order; optional gaps with stray start.
    task automatic drive_mb(input bit gaps, input string tag);
        int n = 0;
        for (int k = 0; k < 16; k++)
            for (int i = 0; i < 4; i++)
                for (int j = 0; j < 4; j++) begin
                    if (gaps && (n % 7 == 6)) begin
                        @(negedge clk);
                        in_valid = 1'b0;
                        in_start = (n == 13);   // R9: start without valid
                        in_res   = 9'sh0AA;
                    end
                    @(negedge clk);
                    in_valid = 1'b1;
                    in_start = (n == 0);
                    in_res   = IN_W'(arr[4*(k/4)+i][4*(k%4)+j]);
                    if (n == 255) begin
                        q_edge.push_back(ecnt + 6);
                        q_val.push_back(model_cost());
                        q_tag.push_back(tag);
                    end
                    n++;
                end
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            in_start = 1'b0;
        end
    endtask

    // Per-clock comparison of strobe timing (R6) and held cost value.
    always @(negedge clk) begin
        if (run_chk && !ended) begin
            bit exp_d;
            exp_d = (q_edge.size() > 0) && (q_edge[0] == ecnt);
            check(cost_done === exp_d, "R6", longint'(cost_done), longint'(exp_d));
            if (exp_d) begin
                hold_val = q_val[0];
                hold_tag = q_tag[0];
                void'(q_edge.pop_front());
                void'(q_val.pop_front());
                void'(q_tag.pop_front());
            end
            check(cost_out === ACC_W'(hold_val), hold_tag, longint'(cost_out), longint'(hold_val));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R6 watchdog: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(cost_done === 1'b0, "R1", longint'(cost_done), 0);
        check(cost_out === '0, "R1", longint'(cost_out), 0);
        rst_n = 1'b1;
        run_chk = 1'b1;
        idle(3);

        // R9: stray samples before any start are ignored.
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_res   = 9'sh07F;
        end
        fill(0); drive_mb(1'b0, "R3"); idle(8);
        fill(1); drive_mb(1'b0, "R4"); idle(8);
        fill(2); drive_mb(1'b0, "R4"); idle(8);
        fill(3); drive_mb(1'b0, "R5"); idle(8);
        fill(4); drive_mb(1'b0, "R3"); idle(8);
        fill(5); drive_mb(1'b0, "R4"); idle(8);

        // R7: three sets back to back with no idle cycles.
        fill(4); drive_mb(1'b0, "R7");
        fill(5); drive_mb(1'b0, "R7");
        fill(3); drive_mb(1'b0, "R7");
        idle(8);

        // R2: gaps in valid, including a start pulse without valid (R9).
        fill(4); drive_mb(1'b1, "R2"); idle(8);

        // R8: abort a set after 100 samples, then send a complete one.
        fill(1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = (i == 0);
            in_res   = 9'sh0FF;
        end
        fill(4); drive_mb(1'b0, "R8"); idle(8);

        // R9: stray samples after a completed set, then a fresh set.
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_start = 1'b0;
            in_res   = -9'sd200;
        end
        fill(5); drive_mb(1'b1, "R9"); idle(12);

        check(q_edge.size() == 0, "R6", q_edge.size(), 0);
        finish_up();
    end
endmodule